// File: doc/BRIEF.md
# Frequency Synthesizer Configuration and Lock Timer

This block holds the reference divider and feedback multiplier settings of one frequency-synthesis loop and tells the rest of the chip when the loop can be trusted. The output ratio of the loop is (MUL + 1) / DIV. Both fields are exposed so that a behavioural loop model or a clock controller can derive the frequency from them. The analog loop is not part of this block. The divided reference and the loop output are represented only by enable levels.

Software writes DIV, MUL, a settling count, a halve-output select and an interrupt enable together, with one write strobe. A write can switch the loop on, or change DIV or MUL while the loop runs. Either way the lock flag drops at once and the settling count is loaded into a down-counter. The counter advances only on a slow-clock tick, which is a single-cycle enable in the register clock domain. The lock flag rises once the count is used up. A write that leaves DIV and MUL unchanged does not disturb a loop that is already locked. A zero DIV holds the reference and the loop output off. A zero MUL powers the loop down.

Top module: `pll_cfg_lock`

## Requirements
- R1: After reset, div_o and mul_o are 0, ref_en, loop_clk_en, locked, irq and half_sel are 0, and pwr_down is 1.
- R2: A cycle with wr_en high loads wr_div, wr_mul, wr_half and wr_irq_en. The new values appear on the outputs after that clock edge. Without wr_en the values are held.
- R3: ref_en is 1 exactly when div_o is nonzero. loop_clk_en is 1 exactly when both div_o and mul_o are nonzero.
- R4: pwr_down is 1 exactly when mul_o is 0.
- R5: A write with wr_div and wr_mul both nonzero starts a settling wait in two cases: the loop was inactive before the write, or either field differs from its held value. The wait clears locked at the same edge and loads wr_cnt. locked then rises on the edge of slow tick number wr_cnt+1 that follows. A count of 0 locks on the first tick.
- R6: A write that leaves div_o or mul_o at 0 clears locked. locked stays 0 through any number of slow ticks until a write that activates the loop.
- R7: A write to an active loop that repeats the held DIV and MUL does not change locked or restart the wait, whatever wr_cnt is.
- R8: irq equals locked AND the stored interrupt enable.
- R9: half_sel follows the stored halve-output bit. Changing it alone does not affect locked.
- R10: Slow ticks with no write change neither div_o nor mul_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for all fields |
| wr_div | input | DIV_W | Reference divider value |
| wr_mul | input | MUL_W | Feedback multiplier value |
| wr_cnt | input | CNT_W | Settling count in slow ticks |
| wr_half | input | 1 | Halve-output select |
| wr_irq_en | input | 1 | Lock interrupt enable |
| slow_tick | input | 1 | One-cycle slow-clock tick enable |
| div_o | output | DIV_W | Active divider |
| mul_o | output | MUL_W | Active multiplier |
| ref_en | output | 1 | Divided reference running |
| loop_clk_en | output | 1 | Loop output running |
| pwr_down | output | 1 | Loop powered down |
| half_sel | output | 1 | Halve-output select |
| locked | output | 1 | Lock status |
| irq | output | 1 | Lock interrupt request |

## Verification
The bench builds the block with DIV_W, MUL_W and CNT_W all set to 3. This makes every divider and multiplier pair (64 of them) small enough to sweep through the enable outputs. It also makes every settling count from 0 to 7 small enough to time tick by tick against count+1. In the same configuration, the bench walks every interrupt-enable and halve-select combination over a locked loop, and checks unchanged rewrites with all count values.

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock #(
  parameter int DIV_W = 8,
  parameter int MUL_W = 11,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_div,
  input  logic [MUL_W-1:0] wr_mul,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_half,
  input  logic             wr_irq_en,
  input  logic             slow_tick,
  output logic [DIV_W-1:0] div_o,
  output logic [MUL_W-1:0] mul_o,
  output logic             ref_en,
  output logic             loop_clk_en,
  output logic             pwr_down,
  output logic             half_sel,
  output logic             locked,
  output logic             irq
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             irq_en_q;

  logic active_now, active_new, changed, restart, stop;

  assign active_now = (div_o != '0) && (mul_o != '0);
  assign active_new = (wr_div != '0) && (wr_mul != '0);
  assign changed    = (wr_div != div_o) || (wr_mul != mul_o);
  assign restart    = wr_en && active_new && (changed || !active_now);
  assign stop       = wr_en && !active_new;

  assign ref_en      = (div_o != '0);
  assign pwr_down    = (mul_o == '0);
  assign loop_clk_en = ref_en && !pwr_down;
  assign irq         = locked && irq_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_o    <= '0;
      mul_o    <= '0;
      half_sel <= 1'b0;
      irq_en_q <= 1'b0;
    end else if (wr_en) begin
      div_o    <= wr_div;
      mul_o    <= wr_mul;
      half_sel <= wr_half;
      irq_en_q <= wr_irq_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      locked <= 1'b0;
    end else if (restart) begin
      cnt_q  <= wr_cnt;
      busy_q <= 1'b1;
      locked <= 1'b0;
    end else if (stop) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      locked <= 1'b0;
    end else if (busy_q && slow_tick) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        locked <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_LOCK_NEEDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> loop_clk_en); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_div != '0 && wr_mul != '0 && (wr_div != div_o || wr_mul != mul_o)) |=> !locked); // R5
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mul == '0) |=> (!locked && pwr_down)); // R6
  AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(slow_tick)); // R5
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(div_o) && $stable(mul_o))); // R10
  AST_SAME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && wr_div == div_o && wr_mul == mul_o) |=> locked); // R7

endmodule

// File: tb/pll_cfg_lock_tb_top.sv
module pll_cfg_lock_tb_top;
  localparam int DW = 3, MW = 3, CW = 3;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_half = 0, wr_irq_en = 0, slow_tick = 0;
  logic [DW-1:0] wr_div = 0;
  logic [MW-1:0] wr_mul = 0;
  logic [CW-1:0] wr_cnt = 0;
  logic [DW-1:0] div_o;
  logic [MW-1:0] mul_o;
  logic ref_en, loop_clk_en, pwr_down, half_sel, locked, irq;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pll_cfg_lock #(.DIV_W(DW), .MUL_W(MW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_div(wr_div), .wr_mul(wr_mul),
    .wr_cnt(wr_cnt), .wr_half(wr_half), .wr_irq_en(wr_irq_en), .slow_tick(slow_tick),
    .div_o(div_o), .mul_o(mul_o), .ref_en(ref_en), .loop_clk_en(loop_clk_en),
    .pwr_down(pwr_down), .half_sel(half_sel), .locked(locked), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int d, input int m, input int c, input bit h, input bit ie);
    @(negedge clk);
    wr_en = 1; wr_div = DW'(d); wr_mul = MW'(m); wr_cnt = CW'(c);
    wr_half = h; wr_irq_en = ie;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); slow_tick = 1;
    @(negedge clk); slow_tick = 0;
  endtask

  task automatic lock_ticks(output int n);
    n = 0;
    while (!locked && n < 20) begin tick(); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(div_o == 0 && mul_o == 0, "R1 cfg", int'(div_o) + int'(mul_o), 0);
    chk(!ref_en && !loop_clk_en && pwr_down, "R1 enables", int'({ref_en, loop_clk_en, pwr_down}), 1);
    chk(!locked && !irq && !half_sel, "R1 status", int'({locked, irq, half_sel}), 0);
    rst_n = 1;
    tick();
    chk(!locked, "R6 tick while idle", locked, 0);

    // R2 R3 R4: sweep every divider and multiplier pair
    for (int d = 0; d < 8; d++)
      for (int m = 0; m < 8; m++) begin
        wr(d, m, 0, 0, 0);
        chk(div_o == DW'(d) && mul_o == MW'(m), "R2 load", int'({div_o, mul_o}), (d << 3) | m);
        chk(ref_en == (d != 0), "R3 ref_en", ref_en, int'(d != 0));
        chk(loop_clk_en == (d != 0 && m != 0), "R3 loop_clk_en", loop_clk_en, int'(d != 0 && m != 0));
        chk(pwr_down == (m == 0), "R4 pwr_down", pwr_down, int'(m == 0));
        if (d != 0 && m != 0) chk(!locked, "R5 clear on write", locked, 0);
      end

    // R5: settling time from re-enable and from parameter change
    for (int c = 0; c < 8; c++) begin
      wr(3, 0, 0, 0, 0);
      wr(3, 5, c, 0, 0);
      lock_ticks(n);
      chk(n == c + 1, "R5 re-enable latency", n, c + 1);
      wr(4, 5, c, 0, 0);
      chk(!locked, "R5 change clears", locked, 0);
      lock_ticks(n);
      chk(n == c + 1, "R5 change latency", n, c + 1);
      wr(4, 6, 7 - c, 0, 0);
      lock_ticks(n);
      chk(n == 8 - c, "R5 mul change latency", n, 8 - c);
    end

    // R10: ticks without writes hold the configuration
    repeat (4) tick();
    chk(div_o == 4 && mul_o == 6, "R10 hold", int'({div_o, mul_o}), (4 << 3) | 6);

    // R7: unchanged rewrite keeps lock, any count
    for (int c = 0; c < 8; c++) begin
      wr(4, 6, c, 0, 0);
      chk(locked, "R7 same keeps lock", locked, 1);
    end

    // R6: power-down and zero divider clear and stay clear
    wr(4, 0, 0, 0, 0);
    chk(!locked, "R6 mul zero", locked, 0);
    repeat (10) tick();
    chk(!locked, "R6 stays clear", locked, 0);
    wr(1, 1, 0, 0, 0);
    lock_ticks(n);
    chk(n == 1, "R5 zero count", n, 1);
    wr(0, 1, 0, 0, 0);
    chk(!locked && !loop_clk_en, "R6 div zero", int'({locked, loop_clk_en}), 0);
    repeat (3) tick();
    chk(!locked, "R6 div zero stays", locked, 0);

    // R8 R9: irq enable and halve select over a locked loop
    wr(2, 2, 1, 0, 0);
    lock_ticks(n);
    for (int k = 0; k < 4; k++) begin
      wr(2, 2, 5, k[1], k[0]);
      chk(locked, "R9 half no effect on lock", locked, 1);
      chk(half_sel == k[1], "R9 half_sel", half_sel, k[1]);
      chk(irq == k[0], "R8 irq locked", irq, k[0]);
    end
    wr(2, 3, 2, 0, 1);
    chk(!irq, "R8 irq cleared with lock", irq, 0);
    lock_ticks(n);
    chk(irq && n == 3, "R8 irq after lock", int'(irq) * 10 + n, 13);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule